// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block counts rendered video lines and interrupts the CPU after a programmed number of them. An 8-bit counter steps down once for each horizontal sync strobe that meets all of these conditions: it falls on a visible line (0 to 239), the display is on, counting is enabled, and no request is already waiting. When the counter is found at zero, the block sets its request flag and drives a level interrupt. It also refills the counter from a reload latch.

The CPU controls the block through single-cycle writes to four decoded addresses. These writes load the counter, load the latch, switch counting off and switch counting on. Any one of these four writes also withdraws a pending request. Line 0 is treated specially: a nonzero count loses one extra step there before the normal test. All state changes happen on the clock edge that samples the write or the sync strobe, so `irq` follows one cycle later.

Top module: `scanirq_counter`

## Requirements
- R1: A sync strobe changes nothing unless `line` is at most 239 and `disp_on` is 1.
- R2: While a request is pending, sync strobes neither change the counter nor the request.
- R3: A qualifying sync strobe on a line other than 0 with a nonzero counter lowers the counter by one and leaves `irq` low.
- R4: A qualifying sync strobe that finds the counter at zero sets `irq` on the next cycle and reloads the counter from the latch.
- R5: A write to address 0xE001 or 0xE801 enables counting; a write to 0xE000 or 0xE800 disables it, after which sync strobes have no effect.
- R6: On line 0 a nonzero counter is first lowered by one extra step, then tested and lowered as in R3/R4 (a count of 1 therefore fires on line 0, a count of 2 reaches zero without firing).
- R7: Each of the four control writes (counter, latch, enable, disable) clears a pending request, so `irq` is 0 on the next cycle.
- R8: After reset the counter, latch, enable and request are all zero, and `irq` is 0.
- R9: Writes are decoded on `wr_addr & 0xFF01`: 0xC000/0xC800 load the counter, 0xC001/0xC801 load the latch; any other decoded value is ignored and leaves a pending request in place.
- R10: When a control write and a qualifying sync strobe arrive in the same cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| hsync | input | 1 | Horizontal sync strobe, one cycle per line |
| line | input | 9 | Current scanline number |
| disp_on | input | 1 | Display enabled flag |
| irq | output | 1 | Registered level interrupt request |

## Verification
The count path is tested with a counter of 3 on ordinary lines. This shows that the fire happens on the fourth strobe and not the third. Small counts of 0, 1 and 2 on line 0 separate the extra line-0 step from the plain step. Strobes are also sent while a request is pending, with the display off, and on lines 240 and above. In each case the bench counts how many strobes it then takes to fire, which shows whether any of the gated strobes were counted by mistake. Mirror addresses and undecoded addresses are also written, and a write is sent in the same cycle as a strobe. Each of these is told apart by whether `irq` clears or keeps its state, and by the fire time that follows.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
  parameter int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic fire;
    cnt_t next;
  } step_t;

  // One qualifying line: optional line-0 pre-step, then test and step.
  function automatic step_t line_step(input cnt_t cur, input logic first_line,
                                      input cnt_t reload);
    step_t r;
    cnt_t  v;
    v = cur;
    if (first_line && (v != '0)) v = v - cnt_t'(1);
    if (v == '0) begin
      r.fire = 1'b1;
      r.next = reload;
    end else begin
      r.fire = 1'b0;
      r.next = v - cnt_t'(1);
    end
    return r;
  endfunction
endpackage

// File: rtl/scanirq_decode.sv
module scanirq_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] DEC_MASK = 16'hFF01,
  parameter logic [15:0] BASE_C   = 16'hC000,
  parameter logic [15:0] BASE_E   = 16'hE000,
  parameter logic [15:0] MIRROR   = 16'h0800
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ld_cnt,
  output logic              ld_lat,
  output logic              set_off,
  output logic              set_on,
  output logic              wr_any
);
  logic [ADDR_W-1:0] key;
  logic [3:0]        hit;
  localparam int NSEL = 4;
  localparam logic [15:0] SEL_ADDR [NSEL] = '{BASE_C, BASE_C | 16'h1,
                                              BASE_E, BASE_E | 16'h1};

  assign key = wr_addr & DEC_MASK[ADDR_W-1:0];

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign hit[i] = wr_en &&
      ((key == SEL_ADDR[i][ADDR_W-1:0]) ||
       (key == (SEL_ADDR[i][ADDR_W-1:0] | MIRROR[ADDR_W-1:0])));
  end

  assign ld_cnt  = hit[0];
  assign ld_lat  = hit[1];
  assign set_off = hit[2];
  assign set_on  = hit[3];
  assign wr_any  = |hit;
endmodule

// File: rtl/scanirq_core.sv
module scanirq_core
  import scanirq_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cnt,
  input  logic              ld_lat,
  input  logic              set_off,
  input  logic              set_on,
  input  logic              wr_any,
  input  cnt_t              wr_data,
  input  logic              hsync,
  input  logic [LINE_W-1:0] line,
  input  logic              disp_on,
  output cnt_t              cnt_q,
  output cnt_t              lat_q,
  output logic              en_q,
  output logic              req_q,
  output logic              tick,
  output logic              fire
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);
  step_t st;

  assign tick = hsync && (line <= LAST) && disp_on && en_q && !req_q && !wr_any;
  assign st   = line_step(cnt_q, line == '0, lat_q);
  assign fire = tick && st.fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else if (wr_any) begin
      req_q <= 1'b0;
      if (ld_cnt)  cnt_q <= wr_data;
      if (ld_lat)  lat_q <= wr_data;
      if (set_off) en_q  <= 1'b0;
      if (set_on)  en_q  <= 1'b1;
    end else if (tick) begin
      cnt_q <= st.next;
      if (st.fire) req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter
  import scanirq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              hsync,
  input  logic [LINE_W-1:0] line,
  input  logic              disp_on,
  output logic              irq
);
  logic ld_cnt, ld_lat, set_off, set_on, wr_any;
  logic en_q, req_q, tick, fire;
  cnt_t cnt_q, lat_q;

  scanirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .ld_cnt(ld_cnt), .ld_lat(ld_lat),
    .set_off(set_off), .set_on(set_on), .wr_any(wr_any)
  );

  scanirq_core #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_core (
    .clk(clk), .rst_n(rst_n), .ld_cnt(ld_cnt), .ld_lat(ld_lat),
    .set_off(set_off), .set_on(set_on), .wr_any(wr_any), .wr_data(wr_data),
    .hsync(hsync), .line(line), .disp_on(disp_on), .cnt_q(cnt_q),
    .lat_q(lat_q), .en_q(en_q), .req_q(req_q), .tick(tick), .fire(fire)
  );

  assign irq = req_q;
endmodule

// File: rtl/scanirq_checker.sv
module scanirq_checker
  import scanirq_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              hsync,
  input logic [LINE_W-1:0] line,
  input logic              disp_on,
  input logic              set_on,
  input logic              set_off,
  input logic              wr_any,
  input logic              tick,
  input logic              fire,
  input logic              en_q,
  input cnt_t              cnt_q,
  input cnt_t              lat_q
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !wr_any && (!disp_on || line > LINE_W'(LAST_LINE))) |=> $stable(cnt_q));

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_any) |=> (irq && $stable(cnt_q)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fire && line != '0) |=> (cnt_q == $past(cnt_q) - cnt_t'(1)) && !irq);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (irq && cnt_q == $past(lat_q)));

  assert_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_on |=> en_q);

  assert_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_off |=> !en_q);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !irq);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && hsync) |=> !irq);
endmodule

bind scanirq_counter scanirq_checker #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .hsync(hsync), .line(line),
  .disp_on(disp_on), .set_on(set_on), .set_off(set_off), .wr_any(wr_any),
  .tick(tick), .fire(fire), .en_q(en_q), .cnt_q(cnt_q), .lat_q(lat_q)
);

// File: tb/tb_scanirq_counter.sv
`timescale 1ns/1ps
module tb_scanirq_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hsync = 1'b0;
  logic [8:0]  line = '0;
  logic        disp_on = 1'b1;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  scanirq_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .line(line), .disp_on(disp_on), .irq(irq)
  );

  task automatic check(input string req, input logic exp);
    n_run++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq=%0b expected=%0b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic hs(input int ln, input logic disp = 1'b1);
    @(negedge clk);
    hsync = 1'b1; line = 9'(ln); disp_on = disp;
    @(posedge clk); #1;
    hsync = 1'b0; disp_on = 1'b1;
  endtask

  task automatic t_reset();
    check("R8 reset irq", 1'b0);
    wr(16'hE001, 8'h00);
    hs(5);
    check("R8 counter zero after reset fires", 1'b1);
    wr(16'hC001, 8'h03);
    check("R7 latch write clears", 1'b0);
  endtask

  task automatic t_count();
    wr(16'hC000, 8'd3);
    for (int i = 0; i < 3; i++) begin
      hs(10 + i);
      check("R3 step without fire", 1'b0);
    end
    hs(13);
    check("R4 fire at zero", 1'b1);
  endtask

  task automatic t_freeze();
    for (int i = 0; i < 6; i++) begin
      hs(14 + i);
      check("R2 request held", 1'b1);
    end
    wr(16'hC801, 8'd3);
    check("R7 latch mirror clears", 1'b0);
    for (int i = 0; i < 3; i++) begin
      hs(20 + i);
      check("R2 R4 reloaded count not consumed", 1'b0);
    end
    hs(23);
    check("R4 fire after reload", 1'b1);
    wr(16'hC000, 8'd2);
    check("R7 counter write clears", 1'b0);
  endtask

  task automatic t_line0();
    hs(0);
    check("R6 count 2 on line 0 no fire", 1'b0);
    hs(1);
    check("R6 fire after line 0 double step", 1'b1);
    wr(16'hC000, 8'd1);
    hs(0);
    check("R6 count 1 fires on line 0", 1'b1);
    wr(16'hC000, 8'd0);
    hs(0);
    check("R6 count 0 fires on line 0", 1'b1);
    wr(16'hC000, 8'd1);
  endtask

  task automatic t_gate();
    hs(5, 1'b0);
    check("R1 display off ignored", 1'b0);
    hs(240);
    check("R1 line 240 ignored", 1'b0);
    hs(400);
    check("R1 line 400 ignored", 1'b0);
    hs(239);
    check("R1 line 239 counts", 1'b0);
    hs(239);
    check("R1 fire after gated strobes", 1'b1);
    wr(16'hC000, 8'd1);
  endtask

  task automatic t_disable();
    wr(16'hE000, 8'h00);
    for (int i = 0; i < 3; i++) begin
      hs(30 + i);
      check("R5 disabled no count", 1'b0);
    end
    wr(16'hC000, 8'd0);
    hs(40);
    check("R5 disabled zero no fire", 1'b0);
    wr(16'hE001, 8'h00);
    hs(41);
    check("R5 enabled fires", 1'b1);
  endtask

  task automatic t_decode();
    wr(16'hA000, 8'h00);
    check("R9 undecoded A000 ignored", 1'b1);
    wr(16'hC102, 8'h00);
    check("R9 undecoded C102 ignored", 1'b1);
    wr(16'hE801, 8'h00);
    check("R5 R7 enable mirror clears", 1'b0);
    wr(16'hC800, 8'd0);
    hs(50);
    check("R9 counter mirror loads zero", 1'b1);
    wr(16'hE000, 8'h00);
    check("R7 disable write clears", 1'b0);
    wr(16'hE001, 8'h00);
  endtask

  task automatic t_same();
    wr(16'hC000, 8'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hC001; wr_data = 8'd5;
    hsync = 1'b1; line = 9'd5;
    @(posedge clk); #1;
    wr_en = 1'b0; hsync = 1'b0;
    check("R10 write wins over strobe", 1'b0);
    hs(6);
    check("R10 counter untouched then fires", 1'b1);
    wr(16'hC001, 8'd5);
    for (int i = 0; i < 5; i++) begin
      hs(60 + i);
      check("R4 reload from latch 5", 1'b0);
    end
    hs(70);
    check("R4 latch 5 fires on sixth", 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_count();
    t_freeze();
    t_line0();
    t_gate();
    t_disable();
    t_decode();
    t_same();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule